// File: doc/BRIEF.md
# Serial Control Register Bank with SPI and I2C Write Access

This block holds sixteen 8-bit control words that steer the rest of the chip, and lets a host processor write them over one of two serial links. A static mode input picks the link. When it is high, the block behaves as a write-only I2C slave. When it is low, it listens as a three-wire SPI receiver, with a select line framing each transfer. Every transfer carries a subaddress byte first and then any number of data bytes. A flag in the subaddress byte makes successive data bytes land in consecutive registers. When the flag is clear, every data byte lands in the same register.

All three bus lines (clock, data and select) are oversampled by the system clock through synchronizer stages. Edges are found inside the clock domain. Both receivers feed one shared byte stream into a single write sequencer. Power-on reset fills every register with 0xFE. The register contents leave the block as one flat parallel vector, with register k at bits [8k+7:8k].

Top module: `ctrl_regbank`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0xFE and the SDA pull-down is inactive.
- R2: With the mode input low, a frame starts when the select input falls and ends when it rises. Bits are sampled on rising serial clock edges, MSB first. The first byte is the subaddress and the following bytes are data. This works with the clock idling low between frames.
- R3: The SPI frame of R2 works the same way with the serial clock idling high before and after the frame.
- R4: If subaddress bit 5 is 1, the data bytes go to consecutive registers, starting at the index in subaddress bits 3..0. After index 15 the next byte goes to index 0.
- R5: If subaddress bit 5 is 0, every data byte of the frame rewrites the register named by bits 3..0, so the last byte wins.
- R6: In SPI mode, a byte cut short by the select input rising writes nothing. The next frame starts again with a fresh subaddress.
- R7: With the mode input high, a write transfer writes the registers with the same subaddress rules. It is made of a start condition, the address byte 0x8C (device address 1000110 followed by write bit 0), the subaddress, the data bytes and a stop condition.
- R8: In a transfer whose address matches, the block pulls SDA low during the ninth clock of every byte, the address byte included. It changes the pull-down only while SCL is low.
- R9: After any other address byte, the block neither acknowledges nor writes anything until the next start condition.
- R10: A partial I2C byte ended by a stop condition writes nothing, and the next transfer is decoded correctly.
- R11: In I2C mode, SPI-style activity on the select line has no effect on the registers. In SPI mode, the SDA pull-down is never asserted and I2C-style traffic has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low power-on reset |
| i2c_mode | input | 1 | Static link choice: 1 = I2C, 0 = SPI |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sel_in | input | 1 | SPI frame select, active low |
| sda_drive_low | output | 1 | Pull SDA low (open-drain acknowledge) |
| regs_flat | output | NREG*8 | All register contents; register k at bits [8k+7:8k] |

## Verification
The hardest situations to reach are the ones where framing state is left behind. Examples are a byte cut off mid-way by a stop condition or by the select line rising, an auto-increment pointer sitting at index 15, and an unmatched I2C address followed by bytes that would be valid data. The stimulus builds these with bit-level bus tasks that can stop after any number of bits. Each truncated transfer is followed by a clean one whose result depends on the bit counter having been cleared. The bench also drives open-drain SDA against the block's own pull-down, so the acknowledge is observed on the same net the block samples.

// File: rtl/ctrl_regbank_pkg.sv
`timescale 1ns/1ps
package ctrl_regbank_pkg;
   localparam int BYTE_W     = 8;
   localparam int IDX_FIELD  = 4;   // subaddress bits 3..0 carry the index
   localparam int AI_BIT     = 5;   // subaddress bit 5 enables auto-increment

   typedef enum logic [1:0] {
      LINK_IDLE,
      LINK_ADDR,
      LINK_DATA,
      LINK_SKIP
   } link_st_t;
endpackage

// File: rtl/cr_sync.sv
`timescale 1ns/1ps
module cr_sync #(
   parameter int           W       = 3,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad
      $error("cr_sync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cr_spi_rx.sv
`timescale 1ns/1ps
module cr_spi_rx
   import ctrl_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel_s,
   input  logic              sel_fall,
   input  logic              scl_rise,
   input  logic              sda_s,
   output logic              frm_start,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat
);
   localparam int CW = $clog2(BYTE_W);

   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] sh_nx;

   assign sh_nx = {sh[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         sh        <= '0;
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
         byte_dat  <= '0;
      end else if (!en) begin
         cnt       <= '0;
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
      end else begin
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
         if (sel_fall) begin
            frm_start <= 1'b1;
            cnt       <= '0;
         end else if (sel_s) begin
            cnt <= '0;                      // partial byte dropped
         end else if (scl_rise) begin
            sh <= sh_nx;
            if (cnt == CW'(BYTE_W-1)) begin
               cnt      <= '0;
               byte_vld <= 1'b1;
               byte_dat <= sh_nx;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cr_i2c_rx.sv
`timescale 1ns/1ps
module cr_i2c_rx
   import ctrl_regbank_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1000110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              scl_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              sda_rise,
   input  logic              sda_fall,
   output logic              frm_start,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_dat,
   output logic              ack_oe
);
   localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};
   localparam int                CW      = $clog2(BYTE_W) + 1;

   link_st_t          st;
   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] sh_nx;
   logic              acking;

   assign sh_nx = {sh[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= LINK_IDLE;
         cnt       <= '0;
         sh        <= '0;
         acking    <= 1'b0;
         ack_oe    <= 1'b0;
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
         byte_dat  <= '0;
      end else if (!en) begin
         st        <= LINK_IDLE;
         cnt       <= '0;
         acking    <= 1'b0;
         ack_oe    <= 1'b0;
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
      end else begin
         frm_start <= 1'b0;
         byte_vld  <= 1'b0;
         if (sda_fall && scl_s) begin            // start or repeated start
            st        <= LINK_ADDR;
            cnt       <= '0;
            acking    <= 1'b0;
            ack_oe    <= 1'b0;
            frm_start <= 1'b1;
         end else if (sda_rise && scl_s) begin   // stop
            st     <= LINK_IDLE;
            cnt    <= '0;
            acking <= 1'b0;
            ack_oe <= 1'b0;
         end else if (st == LINK_ADDR || st == LINK_DATA) begin
            if (acking) begin
               if (scl_fall) begin
                  ack_oe <= 1'b0;
                  acking <= 1'b0;
                  cnt    <= '0;
               end
            end else if (cnt == CW'(BYTE_W)) begin
               if (scl_fall) begin
                  if (st == LINK_ADDR && sh != WR_ADDR) begin
                     st  <= LINK_SKIP;
                     cnt <= '0;
                  end else begin
                     ack_oe <= 1'b1;
                     acking <= 1'b1;
                     st     <= LINK_DATA;
                  end
               end
            end else if (scl_rise) begin
               sh  <= sh_nx;
               cnt <= cnt + 1'b1;
               if (cnt == CW'(BYTE_W-1) && st == LINK_DATA) begin
                  byte_vld <= 1'b1;
                  byte_dat <= sh_nx;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cr_reg_store.sv
`timescale 1ns/1ps
module cr_reg_store
   import ctrl_regbank_pkg::*;
#(
   parameter int                NREG    = 16,
   parameter logic [BYTE_W-1:0] RST_VAL = 8'hFE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   frm_start,
   input  logic                   byte_vld,
   input  logic [BYTE_W-1:0]      byte_dat,
   output logic [NREG*BYTE_W-1:0] regs_flat
);
   localparam int                   IDX_W = $clog2(NREG);
   localparam logic [IDX_FIELD-1:0] LAST  = IDX_FIELD'(NREG-1);
   localparam logic [IDX_FIELD:0]   NLIM  = (IDX_FIELD+1)'(NREG);

   logic [BYTE_W-1:0]    regs [NREG];
   logic [IDX_FIELD-1:0] ptr;
   logic                 ai;
   logic                 have_sub;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= RST_VAL;
         ptr      <= '0;
         ai       <= 1'b0;
         have_sub <= 1'b0;
      end else if (frm_start) begin
         have_sub <= 1'b0;
      end else if (byte_vld) begin
         if (!have_sub) begin
            ptr      <= byte_dat[IDX_FIELD-1:0];
            ai       <= byte_dat[AI_BIT];
            have_sub <= 1'b1;
         end else begin
            if ({1'b0, ptr} < NLIM) regs[ptr[IDX_W-1:0]] <= byte_dat;
            if (ai) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   end

   for (genvar k = 0; k < NREG; k++) begin : g_flat
      assign regs_flat[k*BYTE_W +: BYTE_W] = regs[k];
   end
endmodule

// File: rtl/ctrl_regbank.sv
`timescale 1ns/1ps
module ctrl_regbank
   import ctrl_regbank_pkg::*;
#(
   parameter int                NREG        = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] RST_VAL     = 8'hFE,
   parameter logic [6:0]        DEV_ADDR    = 7'b1000110
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   i2c_mode,
   input  logic                   scl_in,
   input  logic                   sda_in,
   input  logic                   sel_in,
   output logic                   sda_drive_low,
   output logic [NREG*BYTE_W-1:0] regs_flat
);
   if (NREG < 2 || NREG > (1 << IDX_FIELD) || (NREG & (NREG-1)) != 0) begin : g_bad_nreg
      $error("ctrl_regbank: NREG must be a power of two from 2 to 16");
   end

   logic [2:0] raw_v, syn_v;
   logic       scl_s, sda_s, sel_s;
   logic       scl_p, sda_p, sel_p;
   logic       scl_rise, scl_fall, sda_rise, sda_fall, sel_fall;

   assign raw_v = {sel_in, sda_in, scl_in};

   cr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v));

   assign {sel_s, sda_s, scl_s} = syn_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) {sel_p, sda_p, scl_p} <= 3'b111;
      else        {sel_p, sda_p, scl_p} <= syn_v;
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign sda_rise = sda_s & ~sda_p;
   assign sda_fall = ~sda_s & sda_p;
   assign sel_fall = ~sel_s & sel_p;

   logic              spi_start, spi_vld, i2c_start, i2c_vld;
   logic [BYTE_W-1:0] spi_dat, i2c_dat;
   logic              frm_start, byte_vld;
   logic [BYTE_W-1:0] byte_dat;

   cr_spi_rx spi_i (
      .clk(clk), .rst_n(rst_n), .en(!i2c_mode),
      .sel_s(sel_s), .sel_fall(sel_fall), .scl_rise(scl_rise), .sda_s(sda_s),
      .frm_start(spi_start), .byte_vld(spi_vld), .byte_dat(spi_dat));

   cr_i2c_rx #(.DEV_ADDR(DEV_ADDR)) i2c_i (
      .clk(clk), .rst_n(rst_n), .en(i2c_mode),
      .scl_s(scl_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .frm_start(i2c_start), .byte_vld(i2c_vld), .byte_dat(i2c_dat),
      .ack_oe(sda_drive_low));

   assign frm_start = i2c_mode ? i2c_start : spi_start;
   assign byte_vld  = i2c_mode ? i2c_vld   : spi_vld;
   assign byte_dat  = i2c_mode ? i2c_dat   : spi_dat;

   cr_reg_store #(.NREG(NREG), .RST_VAL(RST_VAL)) store_i (
      .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld),
      .byte_dat(byte_dat), .regs_flat(regs_flat));
endmodule

// File: rtl/ctrl_regbank_chk.sv
`timescale 1ns/1ps
module ctrl_regbank_chk #(
   parameter int RW = 128
) (
   input logic          clk,
   input logic          rst_n,
   input logic          i2c_mode,
   input logic          scl_s,
   input logic          sel_s,
   input logic          sda_drive_low,
   input logic          byte_vld,
   input logic          spi_vld,
   input logic          i2c_vld,
   input logic [RW-1:0] regs_flat
);
   // R11
   spi_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_mode |-> !sda_drive_low);

   // R11
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spi_vld, i2c_vld}));

   // R6
   sel_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!i2c_mode && sel_s && $past(sel_s)) |-> !spi_vld);

   // R8
   ack_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_s);

   // R8
   ack_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_low) |-> !scl_s);

   // R2
   hold_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld |=> $stable(regs_flat));
endmodule

bind ctrl_regbank ctrl_regbank_chk #(.RW(NREG*8)) chk_i (
   .clk(clk), .rst_n(rst_n), .i2c_mode(i2c_mode), .scl_s(scl_s), .sel_s(sel_s),
   .sda_drive_low(sda_drive_low), .byte_vld(byte_vld), .spi_vld(spi_vld),
   .i2c_vld(i2c_vld), .regs_flat(regs_flat));

// File: tb/ctrl_regbank_tb_top.sv
`timescale 1ns/1ps
module ctrl_regbank_tb_top;
   localparam int NR = 16;
   localparam int H  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i2c_mode = 1'b0;
   logic scl_m = 1'b0;
   logic sda_m = 1'b1;
   logic sel_m = 1'b1;
   logic sda_drive_low;
   logic [NR*8-1:0] regs_flat;
   wire  sda_bus = sda_m & ~sda_drive_low;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_r [NR];

   always #4 clk = ~clk;

   ctrl_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .i2c_mode(i2c_mode), .scl_in(scl_m),
      .sda_in(sda_bus), .sel_in(sel_m), .sda_drive_low(sda_drive_low),
      .regs_flat(regs_flat));

   typedef struct packed {
      logic        cpol;
      logic [5:0]  nbits;
      logic [31:0] bits;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 6'd16, 32'h035A_0000},   // R2 single write to 3
      '{1'b1, 6'd16, 32'h07C3_0000},   // R3 clock idles high
      '{1'b0, 6'd32, 32'h2E11_2233},   // R4 auto-inc 14,15,0
      '{1'b1, 6'd32, 32'h09A1_A2A3},   // R5 no auto-inc, last wins
      '{1'b0, 6'd27, 32'h2144_55E0},   // R6 3 trailing bits dropped
      '{1'b1, 6'd24, 32'h2F66_7700}    // R4 wrap 15 -> 0
   };

   function automatic logic [NR*8-1:0] exp_flat();
      logic [NR*8-1:0] f;
      for (int k = 0; k < NR; k++) f[k*8 +: 8] = exp_r[k];
      return f;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NR; k++) exp_r[k] = 8'hFE;
   endtask

   // Subaddress: bit 5 auto-increment, bits 3..0 index; wraps 15 -> 0
   task automatic model_frame(input logic [31:0] bits, input int nbits);
      int nb = nbits / 8;
      logic [7:0] sub = bits[31:24];
      logic [3:0] p = sub[3:0];
      for (int b = 1; b < nb; b++) begin
         exp_r[p] = bits[31-8*b -: 8];
         if (sub[5]) p = p + 4'd1;
      end
   endtask

   task automatic check_bank(input string tag);
      n_chk++;
      if (regs_flat !== exp_flat()) begin
         n_bad++;
         $display("FAIL %s: regs actual %h expected %h", tag, regs_flat, exp_flat());
      end
   endtask

   task automatic check_val(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_frame(input logic cpol, input logic [31:0] bits, input int nbits);
      scl_m = cpol;
      wait_cyc(H);
      sel_m = 1'b0;
      wait_cyc(H);
      for (int i = 0; i < nbits; i++) begin
         scl_m = 1'b0;
         sda_m = bits[31-i];
         wait_cyc(H);
         scl_m = 1'b1;
         wait_cyc(H);
      end
      scl_m = cpol;
      wait_cyc(H);
      sel_m = 1'b1;
      sda_m = 1'b1;
      wait_cyc(H);
   endtask

   task automatic i2c_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i];
         wait_cyc(H);
         scl_m = 1'b1;
         wait_cyc(H);
         scl_m = 1'b0;
      end
   endtask

   task automatic i2c_xfer(input logic [7:0] adr, input logic [31:0] bytes,
                           input int nbytes, input int extra, output int acks);
      acks = 0;
      sda_m = 1'b1; scl_m = 1'b1;
      wait_cyc(H);
      sda_m = 1'b0;
      wait_cyc(H);
      scl_m = 1'b0;
      for (int b = 0; b <= nbytes; b++) begin
         i2c_bits(b == 0 ? adr : bytes[31-8*(b-1) -: 8], 8);
         sda_m = 1'b1;
         wait_cyc(H);
         scl_m = 1'b1;
         wait_cyc(H / 2);
         if (sda_drive_low && !sda_bus) acks++;
         wait_cyc(H / 2);
         scl_m = 1'b0;
      end
      if (extra > 0) i2c_bits(8'b1011_0110, extra);
      sda_m = 1'b0;
      wait_cyc(H);
      scl_m = 1'b1;
      wait_cyc(H);
      sda_m = 1'b1;
      wait_cyc(2 * H);
   endtask

   initial begin
      int acks;
      model_reset();
      wait_cyc(5);
      check_bank("R1 in reset");
      check_val("R1 no pull-down in reset", int'(sda_drive_low), 0);
      rst_n = 1'b1;
      wait_cyc(5);
      check_bank("R1 after release");

      foreach (VECS[v]) begin
         spi_frame(VECS[v].cpol, VECS[v].bits, int'(VECS[v].nbits));
         model_frame(VECS[v].bits, int'(VECS[v].nbits));
         check_bank($sformatf("table vector %0d (R2/R3/R4/R5/R6)", v));
      end

      // R6: frame after a cut one must take a new subaddress
      spi_frame(1'b0, 32'h0D3C_0000, 16);
      model_frame(32'h0D3C_0000, 16);
      check_bank("R6 fresh frame after cut");

      i2c_mode = 1'b1;
      wait_cyc(4 * H);
      i2c_xfer(8'h8C, 32'h24B1_B200, 3, 0, acks);
      model_frame(32'h24B1_B200, 24);
      check_bank("R7 i2c auto-inc write");
      check_val("R8 ack count", acks, 4);

      i2c_xfer(8'h9C, 32'h0AEE_0000, 2, 0, acks);
      check_bank("R9 foreign address no write");
      check_val("R9 foreign address no ack", acks, 0);

      i2c_xfer(8'h8C, 32'h0BD4_0000, 2, 5, acks);
      model_frame(32'h0BD4_0000, 16);
      check_bank("R10 stop after partial byte");
      check_val("R10 acks before partial", acks, 3);
      i2c_xfer(8'h8C, 32'h0C5E_0000, 2, 0, acks);
      model_frame(32'h0C5E_0000, 16);
      check_bank("R10 next transfer aligned");

      // R11: SPI traffic in I2C mode ignored
      spi_frame(1'b0, 32'h0099_0000, 16);
      check_bank("R11 spi ignored in i2c mode");

      i2c_mode = 1'b0;
      scl_m = 1'b1;
      wait_cyc(4 * H);
      i2c_xfer(8'h8C, 32'h0177_0000, 2, 0, acks);
      check_bank("R11 i2c ignored in spi mode");
      check_val("R11 no pull-down in spi mode", acks, 0);

      rst_n = 1'b0;
      wait_cyc(3);
      model_reset();
      rst_n = 1'b1;
      wait_cyc(3);
      check_bank("R1 reset reloads defaults");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule